// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This purely combinational block turns one 32-bit instruction word into the control lines that steer a single-cycle processor datapath. It recognises a small integer subset: register-to-register add, subtract, bitwise AND, bitwise OR and set-on-less-than, plus load word, store word, branch-if-equal and an absolute jump. Every other opcode is decoded as a harmless no-operation.

Decoding happens in two levels. The 6-bit opcode alone sets the routing, write and memory enables, along with a 2-bit ALU class. A second decoder turns that class into the 4-bit ALU selector. Memory accesses always add and branches always subtract. Only the register-to-register class looks at the 6-bit function field to choose the operation. The selector is laid out as {invert A, invert B, operation[1:0]}, so a subtract is an add with operand B inverted.

Top module: `instr_ctrl_decoder`

## Requirements
- R1: Opcode 000000 (register class) drives reg_dst=1, alu_src=0, mem_to_reg=0, reg_wr=1, mem_rd=0, mem_wr=0, branch=0, jump=0 and alu_class=10.
- R2: Opcode 100011 (load word) drives reg_dst=0, alu_src=1, mem_to_reg=1, reg_wr=1, mem_rd=1, mem_wr=0, branch=0, jump=0 and alu_class=00.
- R3: Opcode 101011 (store word) drives alu_src=1, mem_wr=1 and alu_class=00, with reg_dst, mem_to_reg, reg_wr, mem_rd, branch and jump all at 0.
- R4: Opcode 000100 (branch-if-equal) drives branch=1 and alu_class=01, with reg_dst, alu_src, mem_to_reg, reg_wr, mem_rd, mem_wr and jump all at 0.
- R5: Opcode 000010 (jump) drives jump=1, with every other single-bit control at 0 and alu_class=00. No other opcode raises jump.
- R6: Any opcode other than the five above drives every single-bit control to 0 and alu_class to 00.
- R7: ALU class 00 gives selector 0010 (add), and class 01 gives 0110 (subtract), whatever the function field holds.
- R8: In the register class, function code 100000 gives selector 0010, 100010 gives 0110, 100100 gives 0000, 100101 gives 0001 and 101010 gives 0111.
- R9: In the register class, any function code not listed in R8 gives selector 0010 (add).
- R10: The opcode is taken from bits 31..26 and the function field from bits 5..0. Bits 25..6 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word to decode |
| reg_dst_o | output | 1 | Destination register comes from the rd field (1) or the rt field (0) |
| alu_src_o | output | 1 | Second ALU operand is the immediate (1) or the second register (0) |
| mem_to_reg_o | output | 1 | Register write data comes from memory (1) or from the ALU (0) |
| reg_wr_o | output | 1 | Register file write enable |
| mem_rd_o | output | 1 | Data memory read enable |
| mem_wr_o | output | 1 | Data memory write enable |
| branch_o | output | 1 | Conditional branch on equal operands |
| jump_o | output | 1 | Absolute jump |
| alu_class_o | output | 2 | ALU class: 00 add, 01 subtract, 10 function field decides |
| alu_sel_o | output | 4 | ALU selector {invert A, invert B, op[1:0]} |

## Verification
Each of the five recognised opcodes is paired with every listed function code, and also with random ones. This separates a selector that really depends on the class from one that leaks the function field into load, store, branch and jump. Random opcodes outside the known set show that unknown encodings fall back to the quiet no-operation, and that jump is not raised by any near-neighbour pattern. Pairs of words that differ only in bits 25..6 are compared to show those bits are ignored. Register-class words with unlisted function codes pin down the add fallback.

// File: rtl/instr_ctrl_pkg.sv
// Package: instr_ctrl_pkg
// Shared encodings for the instruction control decoder: opcode values,
// function codes, ALU selector values, the ALU class type and the bundled
// control struct. Assumes 6-bit opcode and function fields and a 4-bit
// selector laid out as {invert A, invert B, op[1:0]}.
package instr_ctrl_pkg;

    localparam int OP_W      = 6;
    localparam int FN_W      = 6;
    localparam int ALU_SEL_W = 4;
    localparam int NUM_FN    = 5;

    // Opcode encodings
    localparam logic [OP_W-1:0] OPC_REG   = 6'b000000;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
    localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;
    localparam logic [OP_W-1:0] OPC_BREQ  = 6'b000100;
    localparam logic [OP_W-1:0] OPC_JUMP  = 6'b000010;

    // ALU selector encodings
    localparam logic [ALU_SEL_W-1:0] SEL_AND = 4'b0000;
    localparam logic [ALU_SEL_W-1:0] SEL_OR  = 4'b0001;
    localparam logic [ALU_SEL_W-1:0] SEL_ADD = 4'b0010;
    localparam logic [ALU_SEL_W-1:0] SEL_SUB = 4'b0110;
    localparam logic [ALU_SEL_W-1:0] SEL_SLT = 4'b0111;

    // Function-code table for the register class, index-aligned with FN_SEL
    localparam logic [NUM_FN-1:0][FN_W-1:0] FN_CODE = {
        6'b101010,  // set-on-less-than
        6'b100101,  // or
        6'b100100,  // and
        6'b100010,  // subtract
        6'b100000   // add
    };
    localparam logic [NUM_FN-1:0][ALU_SEL_W-1:0] FN_SEL = {
        SEL_SLT, SEL_OR, SEL_AND, SEL_SUB, SEL_ADD
    };

    // ALU class carried from the opcode decoder to the selector decoder
    typedef enum logic [1:0] {
        CLS_MEM = 2'b00,
        CLS_BR  = 2'b01,
        CLS_REG = 2'b10,
        CLS_RSV = 2'b11
    } alu_class_e;

    // Opcode-level control bundle
    typedef struct packed {
        logic       reg_dst;
        logic       alu_src;
        logic       mem_to_reg;
        logic       reg_wr;
        logic       mem_rd;
        logic       mem_wr;
        logic       branch;
        logic       jump;
        alu_class_e cls;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '{
        reg_dst: 1'b0, alu_src: 1'b0, mem_to_reg: 1'b0, reg_wr: 1'b0,
        mem_rd: 1'b0, mem_wr: 1'b0, branch: 1'b0, jump: 1'b0, cls: CLS_MEM
    };

endpackage

// File: rtl/instr_field_split.sv
// Module: instr_field_split
// Pulls the opcode and function fields out of an instruction word.
// Assumes the opcode occupies the top OP_W bits and the function field the
// bottom FN_W bits; the bits between them are left unused here.
module instr_field_split #(
    parameter int INSTR_W = 32,
    parameter int OP_W    = 6,
    parameter int FN_W    = 6
) (
    input  logic [INSTR_W-1:0] instr_i,
    output logic [OP_W-1:0]    opcode_o,
    output logic [FN_W-1:0]    funct_o
);

    localparam int OP_LSB = INSTR_W - OP_W;

    // Field extraction
    assign opcode_o = instr_i[INSTR_W-1:OP_LSB];
    assign funct_o  = instr_i[FN_W-1:0];

endmodule

// File: rtl/opcode_ctrl_decoder.sv
// Module: opcode_ctrl_decoder
// First decode level: maps the opcode onto the routing, write and memory
// controls and the ALU class. Don't-care outputs are tied to 0, and the jump
// opcode and any unknown opcode leave every enable low.
module opcode_ctrl_decoder
    import instr_ctrl_pkg::*;
(
    input  logic [OP_W-1:0] opcode_i,
    output ctrl_t           ctrl_o
);

    // Opcode lookup into the control bundle
    always_comb begin
        ctrl_o = CTRL_IDLE;
        unique case (opcode_i)
            OPC_REG: begin
                ctrl_o.reg_dst = 1'b1;
                ctrl_o.reg_wr  = 1'b1;
                ctrl_o.cls     = CLS_REG;
            end
            OPC_LOAD: begin
                ctrl_o.alu_src    = 1'b1;
                ctrl_o.mem_to_reg = 1'b1;
                ctrl_o.reg_wr     = 1'b1;
                ctrl_o.mem_rd     = 1'b1;
                ctrl_o.cls        = CLS_MEM;
            end
            OPC_STORE: begin
                ctrl_o.alu_src = 1'b1;
                ctrl_o.mem_wr  = 1'b1;
                ctrl_o.cls     = CLS_MEM;
            end
            OPC_BREQ: begin
                ctrl_o.branch = 1'b1;
                ctrl_o.cls    = CLS_BR;
            end
            OPC_JUMP: begin
                ctrl_o.jump = 1'b1;
            end
            default: begin
                ctrl_o = CTRL_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/alu_sel_decoder.sv
// Module: alu_sel_decoder
// Second decode level: turns the ALU class into the ALU selector. Only the
// register class consults the function field, through one comparator per
// table entry; an unlisted function code falls back to add.
module alu_sel_decoder
    import instr_ctrl_pkg::*;
(
    input  alu_class_e           cls_i,
    input  logic [FN_W-1:0]      funct_i,
    output logic [ALU_SEL_W-1:0] sel_o
);

    logic [NUM_FN-1:0]    fn_hit;
    logic [ALU_SEL_W-1:0] fn_sel;

    // One comparator per function-table entry
    for (genvar gi = 0; gi < NUM_FN; gi++) begin : g_fn_match
        assign fn_hit[gi] = (funct_i == FN_CODE[gi]);
    end

    // One-hot AND-OR select over the table, add on a miss
    always_comb begin
        fn_sel = '0;
        for (int i = 0; i < NUM_FN; i++) begin
            fn_sel = fn_sel | (FN_SEL[i] & {ALU_SEL_W{fn_hit[i]}});
        end
        if (fn_hit == '0) begin
            fn_sel = SEL_ADD;
        end
    end

    // Class-level choice of the selector
    always_comb begin
        unique case (cls_i)
            CLS_MEM: sel_o = SEL_ADD;
            CLS_BR:  sel_o = SEL_SUB;
            CLS_REG: sel_o = fn_sel;
            default: sel_o = SEL_ADD;
        endcase
    end

endmodule

// File: rtl/instr_ctrl_decoder.sv
// Module: instr_ctrl_decoder
// Top level of the single-cycle control decoder. Splits the instruction
// into its fields, decodes the opcode, then derives the ALU selector from
// the class and function field. Purely combinational: no clock or reset.
module instr_ctrl_decoder
    import instr_ctrl_pkg::*;
#(
    parameter int INSTR_W = 32
) (
    input  logic [INSTR_W-1:0]   instr_i,
    output logic                 reg_dst_o,
    output logic                 alu_src_o,
    output logic                 mem_to_reg_o,
    output logic                 reg_wr_o,
    output logic                 mem_rd_o,
    output logic                 mem_wr_o,
    output logic                 branch_o,
    output logic                 jump_o,
    output logic [1:0]           alu_class_o,
    output logic [ALU_SEL_W-1:0] alu_sel_o
);

    logic [OP_W-1:0] opcode;
    logic [FN_W-1:0] funct;
    ctrl_t           ctrl;

    instr_field_split #(
        .INSTR_W (INSTR_W),
        .OP_W    (OP_W),
        .FN_W    (FN_W)
    ) u_split (
        .instr_i  (instr_i),
        .opcode_o (opcode),
        .funct_o  (funct)
    );

    opcode_ctrl_decoder u_main (
        .opcode_i (opcode),
        .ctrl_o   (ctrl)
    );

    alu_sel_decoder u_alu (
        .cls_i   (ctrl.cls),
        .funct_i (funct),
        .sel_o   (alu_sel_o)
    );

    // Drive the output ports from the control bundle
    assign reg_dst_o    = ctrl.reg_dst;
    assign alu_src_o    = ctrl.alu_src;
    assign mem_to_reg_o = ctrl.mem_to_reg;
    assign reg_wr_o     = ctrl.reg_wr;
    assign mem_rd_o     = ctrl.mem_rd;
    assign mem_wr_o     = ctrl.mem_wr;
    assign branch_o     = ctrl.branch;
    assign jump_o       = ctrl.jump;
    assign alu_class_o  = ctrl.cls;

endmodule

// File: rtl/instr_ctrl_decoder_chk.sv
// Module: instr_ctrl_decoder_chk
// Consistency checker bound to instr_ctrl_decoder. Because the block has no
// clock, the checks are immediate assertions on the settled port values.
module instr_ctrl_decoder_chk (
    input logic [31:0] instr_i,
    input logic        reg_dst_o,
    input logic        alu_src_o,
    input logic        mem_to_reg_o,
    input logic        reg_wr_o,
    input logic        mem_rd_o,
    input logic        mem_wr_o,
    input logic        branch_o,
    input logic        jump_o,
    input logic [1:0]  alu_class_o,
    input logic [3:0]  alu_sel_o
);

    // Cross-output relations checked whenever the ports settle
    always_comb begin
        assert_reg_dst_writes_R1: assert (!reg_dst_o || (reg_wr_o && !alu_src_o && alu_class_o == 2'b10))
            else $error("reg_dst without a register-class write");
        assert_mem_to_reg_reads_R2: assert (!mem_to_reg_o || (mem_rd_o && reg_wr_o))
            else $error("mem_to_reg without a memory read");
        assert_store_quiet_R3: assert (!mem_wr_o || (!reg_wr_o && !mem_rd_o && alu_src_o))
            else $error("store with a register write or read");
        assert_one_flow_R4: assert ($onehot0({mem_rd_o, mem_wr_o, branch_o, jump_o}))
            else $error("more than one of read/write/branch/jump");
        assert_jump_quiet_R5: assert (!jump_o || (instr_i[31:26] == 6'b000010 && !reg_wr_o && alu_class_o == 2'b00))
            else $error("jump with other activity");
        assert_class_sel_R7: assert ((alu_class_o != 2'b00 || alu_sel_o == 4'b0010) &&
                                     (alu_class_o != 2'b01 || alu_sel_o == 4'b0110))
            else $error("fixed class gave wrong selector");
    end

endmodule

bind instr_ctrl_decoder instr_ctrl_decoder_chk u_chk (
    .instr_i      (instr_i),
    .reg_dst_o    (reg_dst_o),
    .alu_src_o    (alu_src_o),
    .mem_to_reg_o (mem_to_reg_o),
    .reg_wr_o     (reg_wr_o),
    .mem_rd_o     (mem_rd_o),
    .mem_wr_o     (mem_wr_o),
    .branch_o     (branch_o),
    .jump_o       (jump_o),
    .alu_class_o  (alu_class_o),
    .alu_sel_o    (alu_sel_o)
);

// File: tb/instr_ctrl_decoder_test.sv
// Bench for instr_ctrl_decoder: directed corners plus seeded random words,
// compared against a reference model written from the requirements.
module instr_ctrl_decoder_test;

    logic        clk;
    logic        rst_n;
    logic [31:0] instr;
    logic        reg_dst, alu_src, mem_to_reg, reg_wr, mem_rd, mem_wr, branch, jump;
    logic [1:0]  alu_class;
    logic [3:0]  alu_sel;

    int checks;
    int errors;
    int cycles;
    bit done;

    instr_ctrl_decoder uut (
        .instr_i      (instr),
        .reg_dst_o    (reg_dst),
        .alu_src_o    (alu_src),
        .mem_to_reg_o (mem_to_reg),
        .reg_wr_o     (reg_wr),
        .mem_rd_o     (mem_rd),
        .mem_wr_o     (mem_wr),
        .branch_o     (branch),
        .jump_o       (jump),
        .alu_class_o  (alu_class),
        .alu_sel_o    (alu_sel)
    );

    // 200 MHz clock
    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual cycles=%0d expected < 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Reference: {reg_dst, alu_src, mem_to_reg, reg_wr, mem_rd, mem_wr, branch, jump, class[1:0]}
    function automatic logic [9:0] exp_ctrl(input logic [5:0] op);
        case (op)
            6'b000000: return 10'b1001_0000_10;   // R1
            6'b100011: return 10'b0111_1000_00;   // R2
            6'b101011: return 10'b0100_0100_00;   // R3
            6'b000100: return 10'b0000_0010_01;   // R4
            6'b000010: return 10'b0000_0001_00;   // R5
            default:   return 10'b0000_0000_00;   // R6
        endcase
    endfunction

    function automatic logic [3:0] exp_sel(input logic [5:0] op, input logic [5:0] fn);
        if (op == 6'b000100) return 4'b0110;      // R7
        if (op != 6'b000000) return 4'b0010;      // R7
        case (fn)                                 // R8
            6'b100000: return 4'b0010;
            6'b100010: return 4'b0110;
            6'b100100: return 4'b0000;
            6'b100101: return 4'b0001;
            6'b101010: return 4'b0111;
            default:   return 4'b0010;            // R9
        endcase
    endfunction

    function automatic string req_of(input logic [5:0] op, input logic [5:0] fn);
        case (op)
            6'b000000: begin
                case (fn)
                    6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010: return "R1/R8";
                    default: return "R1/R9";
                endcase
            end
            6'b100011: return "R2/R7";
            6'b101011: return "R3/R7";
            6'b000100: return "R4/R7";
            6'b000010: return "R5/R7";
            default:   return "R6/R7";
        endcase
    endfunction

    // Apply one word and compare at the falling edge
    task automatic apply(input logic [31:0] w, input string tag);
        logic [9:0] ec;
        logic [3:0] es;
        logic [9:0] ac;
        @(posedge clk);
        instr = w;
        @(negedge clk);
        ec = exp_ctrl(w[31:26]);
        es = exp_sel(w[31:26], w[5:0]);
        ac = {reg_dst, alu_src, mem_to_reg, reg_wr, mem_rd, mem_wr, branch, jump, alu_class};
        checks = checks + 1;
        if (ac !== ec || alu_sel !== es) begin
            errors = errors + 1;
            $display("FAIL %s instr=%h: actual ctrl=%b sel=%b expected ctrl=%b sel=%b",
                     tag, w, ac, alu_sel, ec, es);
        end
    endtask

    // R10: two words differing only in bits 25..6 must decode alike
    task automatic same_pair(input logic [31:0] w);
        logic [13:0] a0;
        logic [13:0] a1;
        @(posedge clk);
        instr = w & 32'hFC00_003F;
        @(negedge clk);
        a0 = {reg_dst, alu_src, mem_to_reg, reg_wr, mem_rd, mem_wr, branch, jump, alu_class, alu_sel};
        @(posedge clk);
        instr = w | 32'h03FF_FFC0;
        @(negedge clk);
        a1 = {reg_dst, alu_src, mem_to_reg, reg_wr, mem_rd, mem_wr, branch, jump, alu_class, alu_sel};
        checks = checks + 1;
        if (a0 !== a1) begin
            errors = errors + 1;
            $display("FAIL R10 instr=%h: actual %b expected %b", w, a1, a0);
        end
    endtask

    initial begin
        logic [5:0] ops [5];
        logic [5:0] fns [5];
        int unused_seed;
        checks = 0;
        errors = 0;
        cycles = 0;
        done   = 1'b0;
        instr  = 32'h0;
        rst_n  = 1'b0;
        unused_seed = $urandom(32'h1234_5678);
        ops = '{6'b000000, 6'b100011, 6'b101011, 6'b000100, 6'b000010};
        fns = '{6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010};
        repeat (4) @(posedge clk);
        rst_n = 1'b1;

        // Idle word (register class, unlisted function): R1, R9
        apply(32'h0000_0000, "R1/R9 idle");

        // Every opcode with every listed function code: R1..R5, R7, R8
        foreach (ops[i]) begin
            foreach (fns[j]) begin
                apply({ops[i], 20'h0, fns[j]}, req_of(ops[i], fns[j]));
            end
        end

        // Unlisted function codes in the register class: R9
        apply({6'b000000, 20'h0, 6'b111111}, "R9");
        apply({6'b000000, 20'h0, 6'b100001}, "R9");
        apply({6'b000000, 20'h0, 6'b001010}, "R9");

        // Opcodes one bit away from the known ones: R6, R5
        apply({6'b000011, 20'hABCDE, 6'b100000}, "R6 near-jump");
        apply({6'b000110, 20'h0, 6'b100010}, "R6 near-branch");
        apply({6'b100001, 20'h0, 6'b101010}, "R6 near-load");
        apply({6'b111111, 20'hFFFFF, 6'b111111}, "R6 all-ones");

        // Middle bits ignored: R10
        foreach (ops[i]) begin
            same_pair({ops[i], 20'h5A5A5, fns[i]});
        end

        // Random words, biased toward known opcodes and functions
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] w;
            w = $urandom;
            if ($urandom_range(3) != 0) w[31:26] = ops[$urandom_range(4)];
            if ($urandom_range(1) != 0) w[5:0]   = fns[$urandom_range(4)];
            apply(w, req_of(w[31:26], w[5:0]));
            if (n % 100 == 0) same_pair(w);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule